// File: doc/BRIEF.md
# Real-Time Counter and Watchdog with Shared Prescaler

This block pairs an 8-bit real-time counter with a watchdog timer. The two share a single power-of-two prescaler. A write-only mode register sets which unit owns the prescaler and at what ratio. It also selects the counter's source and counting edge, and whether software enables the watchdog. The counter advances on either the core's instruction-cycle strobe or edges on an external pin. The external pin is first passed through a two-flop synchroniser. The watchdog advances on a slow tick that comes from a separate oscillator. That tick arrives in this block as a one-cycle strobe in the `clk` domain.

Whichever unit does not own the prescaler sees its events at 1:1. When the prescaler drives the counter, the ratio is 2^(ps+1). When it drives the watchdog, the ratio is 2^ps, so a ps of 0 bypasses it. Software reloads the counter through a write port and restarts the watchdog with a clear strobe. If the watchdog count rolls over, the block emits a one-cycle reset pulse and sets a sticky time-out flag. A static option input can keep the watchdog running whatever the mode register holds. All pins are plain control and status: no data stream crosses this block, so there is no valid/ready handshake and no back-pressure.

Top module: `tmr_wdt_unit`

## Requirements
- R1: After reset the counter reads 0, the time-out pulse and flag are 0, and the mode register holds FFh. FFh means: watchdog software-disabled, prescaler owned by the watchdog at ps=7, external source, falling edges counted.
- R2: With mode bit 3 = 0 the prescaler belongs to the counter. The counter then advances once per 2^(ps+1) source events, where ps is mode bits 2:0. The counter wraps from 255 to 0.
- R3: With mode bit 3 = 1 the prescaler belongs to the watchdog. The counter then advances once per source event, and the watchdog advances once per 2^ps ticks.
- R4: Mode bit 5 selects the counter source: 0 is the instruction-cycle strobe, 1 is the external pin. With bit 5 = 0, pin activity leaves the counter unchanged.
- R5: Mode bit 4 selects the pin edge that counts: 0 counts rising edges, 1 counts falling edges. Each edge counts once, after a two-flop synchroniser.
- R6: A counter write loads the written value. It takes priority over an increment in the same cycle. If the counter owns the prescaler, the write also empties the prescaler.
- R7: The watchdog runs when mode bit 7 = 0 or the force-on input is 1. While it is stopped, its count is held at zero and no time-out occurs.
- R8: The 256th prescaled watchdog tick after a restart produces a time-out pulse exactly one cycle wide and sets the time-out flag.
- R9: A watchdog clear zeroes the watchdog count and clears the flag. If the watchdog owns the prescaler, the clear also empties it. A clear takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| icyc_stb | input | 1 | Instruction-cycle strobe, one clock wide |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_tick | input | 1 | Watchdog oscillator tick, one clock wide |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 8 | Mode value: [7] wdt off, [5] ext source, [4] falling edge, [3] prescaler to wdt, [2:0] ps |
| cnt_wr | input | 1 | Write strobe for the counter |
| cnt_wdata | input | 8 | Counter load value |
| wdt_clr | input | 1 | Watchdog clear strobe |
| wdt_force_on | input | 1 | Static option keeping the watchdog running |
| cnt_value | output | 8 | Current counter value |
| wdt_timeout | output | 1 | One-cycle watchdog reset pulse |
| wdt_flag | output | 1 | Sticky time-out status |

## Verification
Two pairs of events can land in the same cycle. The first pair is a counter write and a counting event. The bench raises the load strobe and the instruction strobe on the same edge, and expects the loaded value with no increment added. The second pair is a watchdog clear and the tick that would cause roll-over. The bench drives 255 ticks, then presents the clear together with the 256th tick. It expects no pulse at that point, and a pulse only after a further 256 ticks.

// File: rtl/tmr_wdt_pkg.sv
package tmr_wdt_pkg;
  localparam int PS_W   = 3;
  localparam int CNT_W  = 8;
  localparam int WDT_W  = 8;
  localparam int PRE_W  = 2 ** PS_W;

  typedef struct packed {
    logic            wdt_off;
    logic            spare;
    logic            ext_src;
    logic            fall_edge;
    logic            pre_to_wdt;
    logic [PS_W-1:0] ps;
  } mode_t;

  localparam mode_t MODE_RST = '1;
endpackage

// File: rtl/tw_pin_edge.sv
module tw_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              cur;

  assign cur = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= cur;
    end
  end

  assign edge_o = fall_sel ? (prev_q & ~cur) : (cur & ~prev_q);

  AST_EDGE_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o && $stable(fall_sel)) |=> !edge_o); // R5
endmodule

// File: rtl/tw_prescaler.sv
module tw_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_cnt,
  input  logic            ev_wdt,
  input  logic            to_wdt,
  input  logic [PS_W-1:0] ps,
  input  logic            clr,
  output logic            out_cnt,
  output logic            out_wdt
);
  localparam int PRE_W = 2 ** PS_W;

  logic [PRE_W-1:0] pre_q;
  logic [PS_W:0]    shift;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] mask;
  logic             ev;
  logic             hit;

  always_comb begin
    shift = to_wdt ? {1'b0, ps} : ({1'b0, ps} + 1'b1);
    span  = (PRE_W+1)'(1) << shift;
    mask  = PRE_W'(span - 1'b1);
  end

  assign ev  = to_wdt ? ev_wdt : ev_cnt;
  assign hit = ev && !clr && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (clr)    pre_q <= '0;
    else if (ev)     pre_q <= pre_q + 1'b1;
  end

  assign out_cnt = to_wdt ? ev_cnt : hit;
  assign out_wdt = to_wdt ? hit    : ev_wdt;

  AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pre_q == '0)); // R6
  AST_PRE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev && !clr) |=> $stable(pre_q)); // R2
endmodule

// File: rtl/tw_counter.sv
module tw_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (wr)   q <= wdata;
    else if (inc)  q <= q + 1'b1;
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (q == $past(wdata))); // R6
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> (q == $past(q) || q == W'($past(q) + 1'b1))); // R2
endmodule

// File: rtl/tw_watchdog.sv
module tw_watchdog #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic clr,
  output logic timeout,
  output logic flag
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q;
  logic         roll;

  assign roll = en && !clr && tick && (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      timeout <= 1'b0;
      flag    <= 1'b0;
    end else begin
      timeout <= roll;
      if (!en || clr)  cnt_q <= '0;
      else if (tick)   cnt_q <= cnt_q + 1'b1;
      if (roll)        flag <= 1'b1;
      else if (clr)    flag <= 1'b0;
    end
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout); // R8
  AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> flag); // R8
  AST_STOPPED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0 && !timeout)); // R7
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!timeout && !flag && cnt_q == '0)); // R9
endmodule

// File: rtl/tmr_wdt_unit.sv
module tmr_wdt_unit
  import tmr_wdt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             icyc_stb,
  input  logic             ext_pin,
  input  logic             wdt_tick,
  input  logic             mode_wr,
  input  logic [7:0]       mode_wdata,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             wdt_clr,
  input  logic             wdt_force_on,
  output logic [CNT_W-1:0] cnt_value,
  output logic             wdt_timeout,
  output logic             wdt_flag
);
  mode_t mode_q;
  logic  unused_spare;
  logic  pin_edge, cnt_src_ev, pre_clr, cnt_inc, wdt_inc, wdt_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_q <= MODE_RST;
    else if (mode_wr)  mode_q <= mode_t'(mode_wdata);
  end
  assign unused_spare = mode_q.spare;

  tw_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin),
    .fall_sel(mode_q.fall_edge), .edge_o(pin_edge)
  );

  assign cnt_src_ev = mode_q.ext_src ? pin_edge : icyc_stb;
  assign pre_clr    = mode_q.pre_to_wdt ? wdt_clr : cnt_wr;
  assign wdt_en     = !mode_q.wdt_off || wdt_force_on;

  tw_prescaler #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .ev_cnt(cnt_src_ev), .ev_wdt(wdt_tick),
    .to_wdt(mode_q.pre_to_wdt), .ps(mode_q.ps), .clr(pre_clr),
    .out_cnt(cnt_inc), .out_wdt(wdt_inc)
  );

  tw_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(cnt_inc), .wr(cnt_wr),
    .wdata(cnt_wdata), .q(cnt_value)
  );

  tw_watchdog #(.W(WDT_W)) u_wdt (
    .clk(clk), .rst_n(rst_n), .en(wdt_en), .tick(wdt_inc), .clr(wdt_clr),
    .timeout(wdt_timeout), .flag(wdt_flag)
  );

  AST_SRC_INTERNAL_IGNORES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q.ext_src && !icyc_stb && !cnt_wr && !mode_wr) |=> $stable(cnt_value)); // R4
  AST_OWNER_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.pre_to_wdt && !mode_q.ext_src && icyc_stb && !cnt_wr && !mode_wr)
      |=> (cnt_value == CNT_W'($past(cnt_value) + 1'b1))); // R3
endmodule

// File: tb/test_tmr_wdt_unit.sv
module test_tmr_wdt_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       icyc_stb = 1'b0, ext_pin = 1'b0, wdt_tick = 1'b0;
  logic       mode_wr = 1'b0, cnt_wr = 1'b0, wdt_clr = 1'b0, wdt_force_on = 1'b0;
  logic [7:0] mode_wdata = '0, cnt_wdata = '0;
  logic [7:0] cnt_value;
  logic       wdt_timeout, wdt_flag;

  int vectors = 0;
  int errors  = 0;
  int to_seen = 0;
  int to_base = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  tmr_wdt_unit i_tmr_wdt_unit (
    .clk(clk), .rst_n(rst_n), .icyc_stb(icyc_stb), .ext_pin(ext_pin),
    .wdt_tick(wdt_tick), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .wdt_clr(wdt_clr),
    .wdt_force_on(wdt_force_on), .cnt_value(cnt_value),
    .wdt_timeout(wdt_timeout), .wdt_flag(wdt_flag)
  );

  always @(posedge clk) if (rst_n && wdt_timeout) to_seen++;

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic [7:0] m);
    @(negedge clk); mode_wr = 1'b1; mode_wdata = m;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk); cnt_wr = 1'b1; cnt_wdata = v;
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); icyc_stb = 1'b1;
      @(negedge clk); icyc_stb = 1'b0;
    end
    idle(2);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wdt_tick = 1'b1;
      @(negedge clk); wdt_tick = 1'b0;
    end
    idle(3);
  endtask

  task automatic clear_wdt;
    @(negedge clk); wdt_clr = 1'b1;
    @(negedge clk); wdt_clr = 1'b0;
  endtask

  task automatic pin_to(input logic v);
    @(negedge clk); ext_pin = v;
    idle(6);
  endtask

  task automatic mark; to_base = to_seen; endtask

  // pin starts low; three full pulses, then a final rise: 4 rises, 3 falls
  task automatic pin_pattern;
    for (int i = 0; i < 3; i++) begin pin_to(1'b1); pin_to(1'b0); end
    pin_to(1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1: reset values
    check("R1 cnt", cnt_value, 0);
    check("R1 timeout", wdt_timeout, 0);
    check("R1 flag", wdt_flag, 0);
    // R1: reset mode counts falling pin edges at 1:1 and the watchdog stays off
    pin_to(1'b1);
    check("R1 rise ignored", cnt_value, 0);
    pin_to(1'b0);
    check("R1 falling counted", cnt_value, 1);
    mark(); ticks(300);
    check("R1 wdt off", to_seen - to_base, 0);

    // R2: prescaler owned by counter, internal source, sweep of every ratio
    for (int ps = 0; ps < 8; ps++) begin
      int n;
      set_mode(8'h80 | 8'(ps));
      load(8'h00);
      n = (ps + 1) * (1 << (ps + 1)) + (1 << (ps + 1)) - 1;
      strobes(n);
      check($sformatf("R2 ps=%0d", ps), cnt_value, (n >> (ps + 1)) % 256);
    end

    // R3: prescaler with watchdog, counter 1:1, wrap 255->0 (R2)
    set_mode(8'h8F);
    load(8'd250);
    strobes(10);
    check("R3 1:1 with wrap R2", cnt_value, 4);

    // R6: write empties prescaler owned by the counter
    set_mode(8'h82);
    load(8'h00); strobes(5);
    load(8'h00); strobes(7);
    check("R6 prescaler cleared", cnt_value, 0);
    strobes(1);
    check("R6 eighth event", cnt_value, 1);
    // R6: load and increment in same cycle
    set_mode(8'h88);
    load(8'h10);
    @(negedge clk); cnt_wr = 1'b1; cnt_wdata = 8'h55; icyc_stb = 1'b1;
    @(negedge clk); cnt_wr = 1'b0; icyc_stb = 1'b0;
    idle(1);
    check("R6 load beats increment", cnt_value, 8'h55);

    // R4: internal source ignores the pin
    pin_to(1'b0);
    load(8'h00);
    pin_pattern();
    check("R4 pin ignored", cnt_value, 0);
    // R5: rising vs falling on external source, 1:1
    pin_to(1'b0); set_mode(8'hA8); load(8'h00);
    pin_pattern();
    check("R5 rising", cnt_value, 4);
    pin_to(1'b0); set_mode(8'hB8); load(8'h00);
    pin_pattern();
    check("R5 falling", cnt_value, 3);
    // R4 external source with prescaler 1:2
    pin_to(1'b0); set_mode(8'hA0); load(8'h00);
    pin_pattern();
    check("R4 ext prescaled", cnt_value, 2);

    // R8: watchdog 1:1 (prescaler with counter)
    set_mode(8'h00); clear_wdt(); mark();
    ticks(255);
    check("R8 no early timeout", to_seen - to_base, 0);
    check("R8 flag still low", wdt_flag, 0);
    ticks(1);
    check("R8 timeout once", to_seen - to_base, 1);
    check("R8 flag set", wdt_flag, 1);
    // R9: clear restarts count and drops flag
    clear_wdt(); idle(1);
    check("R9 flag cleared", wdt_flag, 0);
    mark(); ticks(200); clear_wdt(); ticks(200);
    check("R9 clear restarts", to_seen - to_base, 0);
    ticks(56);
    check("R9 timeout after restart", to_seen - to_base, 1);
    // R9: clear coincides with the rolling tick
    mark(); ticks(255);
    @(negedge clk); wdt_tick = 1'b1; wdt_clr = 1'b1;
    @(negedge clk); wdt_tick = 1'b0; wdt_clr = 1'b0;
    idle(3);
    check("R9 clear beats roll", to_seen - to_base, 0);
    ticks(255);
    check("R9 count restarted", to_seen - to_base, 0);
    ticks(1);
    check("R9 later roll", to_seen - to_base, 1);

    // R3: watchdog owns prescaler, sweep ps 0..3
    for (int ps = 0; ps < 4; ps++) begin
      set_mode(8'h08 | 8'(ps)); clear_wdt(); mark();
      ticks(256 * (1 << ps) - 1);
      check($sformatf("R3 wdt ps=%0d early", ps), to_seen - to_base, 0);
      ticks(1);
      check($sformatf("R3 wdt ps=%0d roll", ps), to_seen - to_base, 1);
    end

    // R7: software-disabled, then forced on
    set_mode(8'h80); clear_wdt(); mark();
    ticks(300);
    check("R7 disabled", to_seen - to_base, 0);
    wdt_force_on = 1'b1; mark();
    ticks(256);
    check("R7 forced on", to_seen - to_base, 1);
    wdt_force_on = 1'b0;

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule